// File: doc/BRIEF.md
# DMA Transfer Address and Count Registers

This block holds the programming state for a disk DMA engine. It keeps a 14-bit transfer counter, a direction flag, an enable flag and a 22-bit word-aligned memory pointer. A separate engine reads these values and pulses an advance strobe each time it moves one 16-bit word. On each advance the pointer moves forward by two bytes and the counter goes up by one.

The counter register is loaded from the data bus. A read of it returns the count with its two top bits set. The pointer register does not use the data bus at all. Its value comes from the bus address of the write cycle. One address line picks which half of the pointer to replace, and the rest of the address supplies the new bits. The other half is kept.

A count write with the direction flag clear starts one dummy transfer on its own. This shows up as a one-cycle pulse, and the counter advances by one. When the counter rolls over it raises a sticky terminal-count flag.

Top module: `dma_xfer_regs`

## Requirements
- R1: After reset the count, direction, enable, pointer, terminal-count, dummy-pulse and size-error outputs are all zero, and the count readback is 16'hC000.
- R2: An accepted count write (wr_cnt with wr_size = 2'b01, a 16-bit access) loads the count from wr_data[13:0], the direction flag from wr_data[14] and the enable from wr_data[15]. It also clears the terminal-count flag. All of this is visible in the cycle after the write.
- R3: cnt_rdata always equals {2'b11, cnt_val}.
- R4: After an accepted count write with wr_data[14] = 0, dummy_xfer is high for exactly the next cycle, and the count becomes the written value plus one one cycle later. With wr_data[14] = 1 no dummy pulse occurs.
- R5: A pointer write (wr_adr) with bus_addr[14] = 1 loads pointer bits 21:9 from bus_addr[13:1] and keeps pointer bits 8:1.
- R6: A pointer write with bus_addr[14] = 0 loads pointer bits 8:1 from bus_addr[8:1] and keeps pointer bits 21:9.
- R7: A count write whose size is not 16-bit is ignored, and size_err pulses high in the next cycle. Sizes are coded 2'b00 byte, 2'b01 16-bit and 2'b10 32-bit.
- R8: Each adv pulse adds 2 to the pointer (wrapping at 22 bits) and 1 to the count. Pointer bit 0 is always zero.
- R9: The count wraps from 14'h3FFF to 0. Any wrap, whether from adv or from a dummy transfer, sets tc, which stays set until the next accepted count write.
- R10: In a cycle with both a write and an advance, an accepted count write overrides the count increment while the pointer still steps. A pointer write overrides the pointer step while the count still increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cnt | input | 1 | Write strobe for the count register |
| wr_adr | input | 1 | Write strobe for the pointer register |
| bus_addr | input | 24 | Bus address of the write cycle; carries pointer bits |
| wr_data | input | 16 | Write data for the count register |
| wr_size | input | 2 | Access size: 00 byte, 01 16-bit, 10 32-bit |
| adv | input | 1 | One word transferred: advance pointer and count |
| cnt_val | output | 14 | Current transfer count |
| xfer_dir | output | 1 | Direction flag |
| xfer_en | output | 1 | DMA enable flag |
| cnt_rdata | output | 16 | Count register readback |
| dma_addr | output | 22 | Current DMA byte pointer, bit 0 zero |
| dummy_xfer | output | 1 | One-cycle pulse for the automatic dummy transfer |
| size_err | output | 1 | One-cycle pulse on a wrongly sized count write |
| tc | output | 1 | Sticky terminal-count flag |

## Verification
The hardest case to reach is a counter rollover caused by the automatic dummy transfer rather than by the engine. The count must sit at its maximum exactly when the dummy pulse fires. The stimulus gets there by writing 14'h3FFF with the direction flag clear, so the self-triggered increment is the one that wraps. A separate step writes 16'h7FFF and then pulses adv, which covers the engine-driven wrap. Collisions of a write with an advance in the same cycle are driven on purpose to check the priority of each register.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
endpackage

// File: rtl/dma_cnt_reg.sv
module dma_cnt_reg
  import dma_regs_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W+1:0] wdata,
  input  logic [1:0]       size,
  input  logic             adv,
  output logic [CNT_W-1:0] count,
  output logic             dir,
  output logic             en,
  output logic             dummy,
  output logic             tc,
  output logic             size_err
);
  localparam int DIR_BIT = CNT_W;
  localparam int EN_BIT  = CNT_W + 1;

  // count plus increment, carry in the top bit
  function automatic logic [CNT_W:0] cnt_step(input logic [CNT_W-1:0] c,
                                               input logic [1:0] inc);
    return {1'b0, c} + {{(CNT_W-1){1'b0}}, inc};
  endfunction

  logic             wr_ok;
  logic [1:0]       inc;
  logic [CNT_W:0]   nxt;

  assign wr_ok = wr && (size == SZ_HALF);
  assign inc   = {1'b0, dummy} + {1'b0, adv};
  assign nxt   = cnt_step(count, inc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      dir      <= 1'b0;
      en       <= 1'b0;
      dummy    <= 1'b0;
      tc       <= 1'b0;
      size_err <= 1'b0;
    end else begin
      size_err <= wr && !wr_ok;
      dummy    <= wr_ok && !wdata[DIR_BIT];
      if (wr_ok) begin
        count <= wdata[CNT_W-1:0];
        dir   <= wdata[DIR_BIT];
        en    <= wdata[EN_BIT];
        tc    <= 1'b0;
      end else if (inc != 2'd0) begin
        count <= nxt[CNT_W-1:0];
        if (nxt[CNT_W]) tc <= 1'b1;
      end
    end
  end

  // R4: clear direction on an accepted write starts a dummy transfer
  a_r4_dummy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && !wdata[DIR_BIT] |=> dummy);
  // R4: the dummy transfer advances the count by one
  a_r4_dummy_incr: assert property (@(posedge clk) disable iff (!rst_n)
    dummy && !wr && !adv |=> count == CNT_W'($past(count) + 1'b1));
  // R7: wrong size raises the flag and leaves the count alone
  a_r7_size_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr && size != SZ_HALF && !adv && !dummy |=> size_err && $stable(count));
  // R9: rolling over from all ones sets terminal count
  a_r9_tc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (&count) && adv && !wr && !dummy |=> tc && count == '0);
  // R2: an accepted write clears terminal count
  a_r2_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !tc);
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int ADDR_W  = 22,
  parameter int LO_TOP  = 8,
  parameter int BUS_AW  = 24,
  parameter int SEL_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              adv,
  output logic [ADDR_W-1:0] dma_addr
);
  localparam int HI_W = ADDR_W - 1 - LO_TOP;  // pointer bits above the low half
  localparam int PW   = ADDR_W - 1;           // stored bits, bit 0 is implicit

  // stored pointer holds bits ADDR_W-1..1
  function automatic logic [PW-1:0] load_hi(input logic [PW-1:0] cur,
                                            input logic [BUS_AW-1:0] ba);
    return {ba[HI_W:1], cur[LO_TOP-1:0]};
  endfunction

  function automatic logic [PW-1:0] load_lo(input logic [PW-1:0] cur,
                                            input logic [BUS_AW-1:0] ba);
    return {cur[PW-1:LO_TOP], ba[LO_TOP:1]};
  endfunction

  function automatic logic [PW-1:0] word_step(input logic [PW-1:0] cur);
    return cur + 1'b1;
  endfunction

  logic [PW-1:0] ptr;
  logic          unused_bus;

  assign unused_bus = ^{bus_addr[BUS_AW-1:SEL_BIT+1], bus_addr[SEL_BIT-1:HI_W+1], bus_addr[0]};
  assign dma_addr   = {ptr, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr) begin
      ptr <= bus_addr[SEL_BIT] ? load_hi(ptr, bus_addr) : load_lo(ptr, bus_addr);
    end else if (adv) begin
      ptr <= word_step(ptr);
    end
  end

  // R5: high-half write keeps the low half
  a_r5_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr[SEL_BIT] |=> dma_addr[LO_TOP:1] == $past(dma_addr[LO_TOP:1]));
  // R6: low-half write keeps the high half
  a_r6_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !bus_addr[SEL_BIT] |=> dma_addr[ADDR_W-1:LO_TOP+1] == $past(dma_addr[ADDR_W-1:LO_TOP+1]));
  // R8: an advance moves the pointer by two bytes
  a_r8_step_two: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wr |=> dma_addr == ADDR_W'($past(dma_addr) + 2));
endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs #(
  parameter int CNT_W   = 14,
  parameter int ADDR_W  = 22,
  parameter int LO_TOP  = 8,
  parameter int BUS_AW  = 24,
  parameter int SEL_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cnt,
  input  logic              wr_adr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [CNT_W+1:0]  wr_data,
  input  logic [1:0]        wr_size,
  input  logic              adv,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              xfer_dir,
  output logic              xfer_en,
  output logic [CNT_W+1:0]  cnt_rdata,
  output logic [ADDR_W-1:0] dma_addr,
  output logic              dummy_xfer,
  output logic              size_err,
  output logic              tc
);
  dma_cnt_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr_cnt),
    .wdata    (wr_data),
    .size     (wr_size),
    .adv      (adv),
    .count    (cnt_val),
    .dir      (xfer_dir),
    .en       (xfer_en),
    .dummy    (dummy_xfer),
    .tc       (tc),
    .size_err (size_err)
  );

  dma_addr_reg #(
    .ADDR_W  (ADDR_W),
    .LO_TOP  (LO_TOP),
    .BUS_AW  (BUS_AW),
    .SEL_BIT (SEL_BIT)
  ) u_adr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr_adr),
    .bus_addr (bus_addr),
    .adv      (adv),
    .dma_addr (dma_addr)
  );

  // readback forces the two flag positions high
  assign cnt_rdata = {2'b11, cnt_val};

  // R3: readback tracks the live count
  a_r3_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rdata[CNT_W-1:0] == cnt_val && (&cnt_rdata[CNT_W+1:CNT_W]));
  // R8: pointer is always word aligned
  a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    dma_addr[0] == 1'b0);
endmodule

// File: tb/dma_xfer_regs_tb.sv
module dma_xfer_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_cnt, wr_adr, adv;
  logic [23:0] bus_addr;
  logic [15:0] wr_data;
  logic [1:0]  wr_size;
  logic [13:0] cnt_val;
  logic        xfer_dir, xfer_en, dummy_xfer, size_err, tc;
  logic [15:0] cnt_rdata;
  logic [21:0] dma_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dma_xfer_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_adr(wr_adr),
    .bus_addr(bus_addr), .wr_data(wr_data), .wr_size(wr_size), .adv(adv),
    .cnt_val(cnt_val), .xfer_dir(xfer_dir), .xfer_en(xfer_en),
    .cnt_rdata(cnt_rdata), .dma_addr(dma_addr), .dummy_xfer(dummy_xfer),
    .size_err(size_err), .tc(tc)
  );

  // pointer-write vectors: {bus address, expected pointer}, applied in order
  localparam logic [45:0] ADR_VEC [4] = '{
    {24'h007578, 22'h357800},   // R5 high half 0x1ABC
    {24'hF0B14A, 22'h35794A},   // R6 low half 0xA5, junk elsewhere
    {24'h804003, 22'h00034A},   // R5 high half 1, low kept
    {24'h000001, 22'h000200}    // R6 low half 0, high kept
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_cnt = 0; wr_adr = 0; adv = 0;
  endtask

  // drive for one clock; returns at the negedge after the edge
  task automatic cnt_wr(logic [15:0] d, logic [1:0] sz);
    @(negedge clk); wr_cnt = 1; wr_data = d; wr_size = sz;
    @(negedge clk); idle();
  endtask

  task automatic adr_wr(logic [23:0] a);
    @(negedge clk); wr_adr = 1; bus_addr = a;
    @(negedge clk); idle();
  endtask

  task automatic step();
    @(negedge clk); adv = 1;
    @(negedge clk); idle();
  endtask

  initial begin
    idle(); bus_addr = '0; wr_data = '0; wr_size = 2'b01; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", cnt_val, 0);
    chk("R1 rdata", cnt_rdata, 16'hC000);
    chk("R1 addr", dma_addr, 0);
    chk("R1 flags", {xfer_dir, xfer_en, tc, dummy_xfer, size_err}, 0);

    for (int i = 0; i < 4; i++) begin
      adr_wr(ADR_VEC[i][45:22]);
      chk(ADR_VEC[i][36] ? "R5 hi load" : "R6 lo load", dma_addr, ADR_VEC[i][21:0]);
    end

    // R8 pointer wrap
    adr_wr(24'h007FFE);
    adr_wr(24'h0001FE);
    chk("R8 top", dma_addr, 22'h3FFFFE);
    step();
    chk("R8 addr wrap", dma_addr, 0);
    chk("R8 count inc", cnt_val, 1);

    // R2/R3 write with direction set: no dummy
    cnt_wr(16'hC123, 2'b01);
    chk("R2 count", cnt_val, 14'h0123);
    chk("R2 en/dir", {xfer_en, xfer_dir}, 2'b11);
    chk("R4 no dummy", dummy_xfer, 0);
    chk("R3 rdata", cnt_rdata, 16'hC123);
    @(negedge clk);
    chk("R4 no incr", cnt_val, 14'h0123);

    // R4 dummy transfer
    cnt_wr(16'h8010, 2'b01);
    chk("R4 dummy pulse", dummy_xfer, 1);
    chk("R4 count pre", cnt_val, 14'h0010);
    @(negedge clk);
    chk("R4 count post", cnt_val, 14'h0011);
    chk("R4 pulse end", dummy_xfer, 0);
    chk("R3 rdata2", cnt_rdata, 16'hC011);
    chk("R2 dir clear", {xfer_en, xfer_dir}, 2'b10);

    // R7 wrong sizes ignored
    cnt_wr(16'h0005, 2'b00);
    chk("R7 byte err", size_err, 1);
    chk("R7 byte ignored", cnt_val, 14'h0011);
    cnt_wr(16'h4007, 2'b10);
    chk("R7 word err", size_err, 1);
    chk("R7 word ignored", {xfer_en, xfer_dir, cnt_val}, {2'b10, 14'h0011});
    @(negedge clk);
    chk("R7 err pulse", size_err, 0);

    // R9 wrap by advance
    cnt_wr(16'h7FFF, 2'b01);
    chk("R9 preset", cnt_val, 14'h3FFF);
    step();
    chk("R9 wrap count", cnt_val, 0);
    chk("R9 tc set", tc, 1);
    step();
    chk("R9 tc sticky", tc, 1);
    cnt_wr(16'h4000, 2'b01);
    chk("R9 tc cleared", tc, 0);

    // R9 wrap by dummy transfer
    cnt_wr(16'h3FFF, 2'b01);
    chk("R9 dummy preset", {dummy_xfer, tc}, 2'b10);
    @(negedge clk);
    chk("R9 dummy wrap", cnt_val, 0);
    chk("R9 dummy tc", tc, 1);

    // R10 collisions
    adr_wr(24'h004000);
    adr_wr(24'h000000);
    cnt_wr(16'h4005, 2'b01);
    @(negedge clk); wr_cnt = 1; wr_data = 16'h4100; wr_size = 2'b01; adv = 1;
    @(negedge clk); idle();
    chk("R10 count wins", cnt_val, 14'h0100);
    chk("R10 ptr steps", dma_addr, 22'h2);
    @(negedge clk); wr_adr = 1; bus_addr = 24'h000010; adv = 1;
    @(negedge clk); idle();
    chk("R10 ptr write wins", dma_addr, 22'h10);
    chk("R10 count steps", cnt_val, 14'h0101);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule